// File: doc/BRIEF.md
# GPIO Port Register Bank

A 32-pin general-purpose I/O port controlled through a plain memory-mapped register interface: a byte address, a write strobe, 32-bit write data and 32-bit combinational read data. Bit n of every register belongs to pin n. The bank holds a per-pin direction register, an output data register and a synchronized sample of the pad inputs. It drives a value and an output enable onto each external pad.

The direction register is active-low for output: a 1 leaves the pin as an input and a 0 drives it. Software can change any group of output bits in a single write through two write-only alias addresses. One alias sets the bits written as 1 and the other clears them. No read-modify-write sequence is needed, so two agents that own different pins cannot undo each other's updates.

Pad electrical behaviour, muxing, clock gating and interrupts are left to neighbouring logic. The decoder has no states: each access is resolved in the cycle it is presented. Selects are NONE, DIR, IN, OUT, CLR and SET.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the direction register reads all ones, the output register reads zero, pad_oe is all zeros and pad_out is all zeros.
- R2: A write at byte address 0x134 replaces the direction register. A read at 0x134 returns it, and pad_oe bit n is the inverse of direction bit n.
- R3: A write at 0x13C replaces the output register. A read at 0x13C returns it, and pad_out equals it whatever the direction bits are.
- R4: A write at 0x194 sets each output bit whose write-data bit is 1 and leaves every other bit unchanged.
- R5: A write at 0x190 clears each output bit whose write-data bit is 1 and leaves every other bit unchanged.
- R6: A read at 0x138 returns pad_in as it was sampled two rising clock edges earlier, through a two-flop synchronizer. A write at 0x138 changes no register.
- R7: Reads at 0x190 and 0x194 return the current output register.
- R8: A read at any other address returns zero, and a write there changes neither pad_out nor pad_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Per-pin output value |
| pad_oe | output | 32 | Per-pin output enable, 1 drives the pad |

## Verification
The bench targets the alias writes with masks that overlap bits already set and bits already clear. A design that wrote the data directly instead of merging it, or that swapped set and clear, would lose untouched pins. It reads the input register one edge and two edges after a pad change, which exposes a synchronizer with one stage or three. It also writes to the read-only input address and to unmapped addresses and then reads back the direction and output registers, which catches a loose decoder that aliases them onto a live register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned NPINS    = 32;
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned SYNC_LEN = 2;

    localparam logic [ADDR_W-1:0] OFF_DIR = 12'h134;
    localparam logic [ADDR_W-1:0] OFF_IN  = 12'h138;
    localparam logic [ADDR_W-1:0] OFF_OUT = 12'h13C;
    localparam logic [ADDR_W-1:0] OFF_CLR = 12'h190;
    localparam logic [ADDR_W-1:0] OFF_SET = 12'h194;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_IN,
        SEL_OUT,
        SEL_CLR,
        SEL_SET
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        unique case (addr)
            OFF_DIR: sel = SEL_DIR;
            OFF_IN:  sel = SEL_IN;
            OFF_OUT: sel = SEL_OUT;
            OFF_CLR: sel = SEL_CLR;
            OFF_SET: sel = SEL_SET;
            default: sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            out_q <= '0;
        end else if (we) begin
            case (sel)
                SEL_DIR: dir_q <= wdata;
                SEL_OUT: out_q <= wdata;
                SEL_SET: out_q <= out_q | wdata;
                SEL_CLR: out_q <= out_q & ~wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    reg_sel_e         sel;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] in_sync;

    gpio_addr_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_out_regs #(.WIDTH(NPINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .we    (bus_we),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .out_q (out_q)
    );

    gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    always_comb begin
        unique case (sel)
            SEL_DIR:                   bus_rdata = dir_q;
            SEL_IN:                    bus_rdata = in_sync;
            SEL_OUT, SEL_CLR, SEL_SET: bus_rdata = out_q;
            default:                   bus_rdata = '0;
        endcase
    end

    assign pad_out = out_q;
    assign pad_oe  = ~dir_q;
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk
    import gpio_bank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe
);
    logic [1:0] age;
    logic       mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assign mapped = (bus_addr == OFF_DIR) || (bus_addr == OFF_IN) ||
                    (bus_addr == OFF_OUT) || (bus_addr == OFF_CLR) ||
                    (bus_addr == OFF_SET);

    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_SET) |=> pad_out == ($past(pad_out) | $past(bus_wdata)));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_CLR) |=> pad_out == ($past(pad_out) & ~$past(bus_wdata)));

    p_dir_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_DIR) |-> bus_rdata == ~pad_oe);

    p_alias_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_SET || bus_addr == OFF_CLR || bus_addr == OFF_OUT) |-> bus_rdata == pad_out);

    p_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_IN && age >= 2'd2) |-> bus_rdata == $past(pad_in, 2));

    p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == '0);

    p_unmapped_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (!mapped || bus_addr == OFF_IN)) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_port_bank gpio_port_bank_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/test_gpio_port_bank.sv
module test_gpio_port_bank;
    localparam int unsigned CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    gpio_port_bank i_gpio_port_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; bus_addr = 12'h000;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset_r1();
        logic [31:0] v;
        rd(12'h134, v); chk("R1 dir", v, 32'hFFFF_FFFF);
        rd(12'h13C, v); chk("R1 out", v, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 pad_out", pad_out, 32'h0);
    endtask

    task automatic t_dir_r2();
        logic [31:0] v;
        wr(12'h134, 32'hF0F0_1234);
        rd(12'h134, v); chk("R2 dir readback", v, 32'hF0F0_1234);
        chk("R2 pad_oe", pad_oe, 32'h0F0F_EDCB);
    endtask

    task automatic t_out_r3();
        logic [31:0] v;
        wr(12'h13C, 32'hA5A5_0F0F);
        rd(12'h13C, v); chk("R3 out readback", v, 32'hA5A5_0F0F);
        chk("R3 pad_out", pad_out, 32'hA5A5_0F0F);
    endtask

    task automatic t_set_r4();
        wr(12'h194, 32'h0000_FF00);
        chk("R4 set merge", pad_out, 32'hA5A5_FF0F);
        wr(12'h194, 32'h0);
        chk("R4 zero mask", pad_out, 32'hA5A5_FF0F);
    endtask

    task automatic t_clr_r5();
        wr(12'h190, 32'hFF00_000F);
        chk("R5 clear merge", pad_out, 32'h00A5_FF00);
        wr(12'h190, 32'h0);
        chk("R5 zero mask", pad_out, 32'h00A5_FF00);
    endtask

    task automatic t_alias_read_r7();
        logic [31:0] v;
        rd(12'h190, v); chk("R7 clear alias read", v, 32'h00A5_FF00);
        rd(12'h194, v); chk("R7 set alias read", v, 32'h00A5_FF00);
    endtask

    task automatic t_sync_r6();
        logic [31:0] v;
        @(negedge clk);
        pad_in = 32'hDEAD_BEEF;
        @(negedge clk);
        rd(12'h138, v); chk("R6 one edge still old", v, 32'h0);
        @(negedge clk);
        rd(12'h138, v); chk("R6 two edges new", v, 32'hDEAD_BEEF);
        wr(12'h138, 32'h1234_5678);
        rd(12'h134, v); chk("R6 write ignored dir", v, 32'hF0F0_1234);
        rd(12'h13C, v); chk("R6 write ignored out", v, 32'h00A5_FF00);
    endtask

    task automatic t_unmapped_r8();
        logic [31:0] v;
        rd(12'h000, v); chk("R8 read 0x000", v, 32'h0);
        rd(12'h135, v); chk("R8 read 0x135", v, 32'h0);
        rd(12'h034, v); chk("R8 read 0x034", v, 32'h0);
        wr(12'h034, 32'h0);
        wr(12'h03C, 32'hFFFF_FFFF);
        wr(12'h198, 32'hFFFF_FFFF);
        chk("R8 pad_out kept", pad_out, 32'h00A5_FF00);
        chk("R8 pad_oe kept", pad_oe, 32'h0F0F_EDCB);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_dir_r2();
        t_out_r3();
        t_set_r4();
        t_clr_r5();
        t_alias_read_r7();
        t_sync_r6();
        t_unmapped_r8();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule